// File: doc/BRIEF.md
# SGI Range-Selector Command Generator

This block turns a set of destination processors into a stream of 64-bit
software-generated-interrupt command words. Every processor has a four-level
affinity identifier, and its row in an indexed affinity table gives that
identifier. A start strobe captures the processor mask, the interrupt number,
the range-selector capability flag and, by default, the table. The block then
visits the processors in ascending index order. Each processor whose mask bit
is set joins the current command when its upper affinity and its 16-wide
level-0 range match the open group. Otherwise the open command is sent first and
that processor opens a new one.

Level-0 affinity values above 15 are carried as a 4-bit range selector plus a
16-bit target list. When range selection is not supported, only range zero can
be reached. A processor in any other range is dropped and an error flag is
raised. Commands leave on a valid/ready stream. A one-cycle done pulse closes
every run.

Top module: `sgi_rs_cmdgen`

## Requirements
- R1: After reset `cmd_valid_o`, `done_o` and `err_o` are all low.
- R2: Affinity table row i is `aff_tbl_i[32*i +: 32]`, packed as level 3 in [31:24], level 2 in [23:16], level 1 in [15:8] and level 0 in [7:0]. The command word carries the target list in [15:0], level 1 in [23:16], level 2 in [39:32], the range selector in [47:44] and level 3 in [55:48]. All other bits not named in R9 are zero.
- R3: Two processors share one command only when levels 3, 2 and 1 and level-0 bits [7:4] all match. The range selector is level-0 bits [7:4], and target-list bit n is set for a processor whose level-0 bits [3:0] equal n.
- R4: Processors are visited in ascending index order. A set processor whose group differs from the open one causes the open command to be emitted first, so the group sequence A, B, A yields three commands.
- R5: Processors whose mask bit is clear add nothing, and they do not split a group.
- R6: With range support off, a set processor whose level-0 bits [7:4] are nonzero is left out of every command. `err_o` then goes high and stays high until the next start. No emitted word then has a nonzero range selector.
- R7: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_word_o` does not change.
- R8: `done_o` pulses for exactly one cycle after the last command is accepted, and never together with `cmd_valid_o`. An empty mask, or a mask with only unreachable processors, gives the done pulse and no command.
- R9: The interrupt number is placed in bits [27:24], and the routing-mode bit 40 is always zero (targeted delivery).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; accepted only when idle |
| cpu_mask_i | input | NUM_CPU | Destination processor mask |
| aff_tbl_i | input | 32*NUM_CPU | Per-processor affinity table |
| intid_i | input | 4 | Interrupt number |
| rs_sup_i | input | 1 | Range selection supported |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Consumer accepts the word |
| cmd_word_o | output | 64 | Command word |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | An unreachable target was dropped |

## Verification
The bench targets groups that break only on the range selector, which a design that compared only upper affinity would fold into one word. It also targets the same group returning after a different one, which a merging design would cover with two commands instead of three. Masks with holes inside one group would be split by a design that closed groups on any clear bit. Runs with range support off would go wrong if the design kept unreachable processors or left the error flag low. An empty mask and an all-unreachable mask would hang or emit an empty word in a design that did not handle them. A stalled consumer would see the word change if the design advanced under backpressure.

// File: rtl/sgi_rs_pkg.sv
package sgi_rs_pkg;
   localparam int AFF_W   = 8;
   localparam int ROW_W   = 4 * AFF_W;
   localparam int TLIST_W = 16;
   localparam int WORD_W  = 64;

   typedef struct packed {
      logic [AFF_W-1:0] lvl3;
      logic [AFF_W-1:0] lvl2;
      logic [AFF_W-1:0] lvl1;
      logic [3:0]       rsel;
   } grp_key_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_EMIT = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sgi_rs_key.sv
module sgi_rs_key
   import sgi_rs_pkg::*;
(
   input  logic [ROW_W-1:0] row_i,
   output grp_key_t         key_o,
   output logic [3:0]       bit_o
);
   assign key_o.lvl3 = row_i[31:24];
   assign key_o.lvl2 = row_i[23:16];
   assign key_o.lvl1 = row_i[15:8];
   assign key_o.rsel = row_i[7:4];
   assign bit_o      = row_i[3:0];
endmodule

// File: rtl/sgi_rs_pack.sv
module sgi_rs_pack
   import sgi_rs_pkg::*;
(
   input  grp_key_t           key_i,
   input  logic [TLIST_W-1:0] tlist_i,
   input  logic [3:0]         intid_i,
   output logic [WORD_W-1:0]  word_o
);
   always_comb begin
      word_o        = '0;
      word_o[15:0]  = tlist_i;
      word_o[23:16] = key_i.lvl1;
      word_o[27:24] = intid_i;
      word_o[39:32] = key_i.lvl2;
      word_o[40]    = 1'b0;
      word_o[47:44] = key_i.rsel;
      word_o[55:48] = key_i.lvl3;
   end
endmodule

// File: rtl/sgi_rs_cmdgen.sv
module sgi_rs_cmdgen
   import sgi_rs_pkg::*;
#(
   parameter int NUM_CPU     = 8,
   parameter bit LATCH_TABLE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [NUM_CPU-1:0]       cpu_mask_i,
   input  logic [ROW_W*NUM_CPU-1:0] aff_tbl_i,
   input  logic [3:0]               intid_i,
   input  logic                     rs_sup_i,
   output logic                     cmd_valid_o,
   input  logic                     cmd_ready_i,
   output logic [WORD_W-1:0]        cmd_word_o,
   output logic                     done_o,
   output logic                     err_o
);
   localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPU - 1);

   if (NUM_CPU < 2 || NUM_CPU > 256) begin : g_bad_num_cpu
      $error("sgi_rs_cmdgen: NUM_CPU must lie in 2..256");
   end

   seq_state_t                state_q;
   logic [IDX_W-1:0]          idx_q;
   logic [NUM_CPU-1:0]        mask_q;
   logic [3:0]                intid_q;
   logic                      rs_en_q;
   logic                      open_q;
   logic                      last_q;
   logic                      err_q;
   grp_key_t                  gkey_q;
   logic [TLIST_W-1:0]        tlist_q;
   logic [ROW_W*NUM_CPU-1:0]  tbl_use;

   // Table source: captured at start, or taken live from the port
   if (LATCH_TABLE) begin : g_tbl_reg
      logic [ROW_W*NUM_CPU-1:0] tbl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             tbl_q <= '0;
         else if (state_q == ST_IDLE && start_i) tbl_q <= aff_tbl_i;
      end
      assign tbl_use = tbl_q;
   end else begin : g_tbl_live
      assign tbl_use = aff_tbl_i;
   end

   logic [ROW_W-1:0] cur_row;
   grp_key_t         cur_key;
   logic [3:0]       cur_bit;
   logic             cur_hit;
   logic             cur_unreach;

   assign cur_row = tbl_use[ROW_W*idx_q +: ROW_W];

   sgi_rs_key u_key (
      .row_i (cur_row),
      .key_o (cur_key),
      .bit_o (cur_bit)
   );

   assign cur_hit     = mask_q[idx_q];
   assign cur_unreach = cur_hit && !rs_en_q && (cur_key.rsel != 4'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         mask_q  <= '0;
         intid_q <= '0;
         rs_en_q <= 1'b0;
         open_q  <= 1'b0;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         gkey_q  <= '0;
         tlist_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               mask_q  <= cpu_mask_i;
               intid_q <= intid_i;
               rs_en_q <= rs_sup_i;
               idx_q   <= '0;
               open_q  <= 1'b0;
               last_q  <= 1'b0;
               err_q   <= 1'b0;
               tlist_q <= '0;
               state_q <= ST_SCAN;
            end
            ST_SCAN: begin
               if (cur_hit && !cur_unreach && open_q && (cur_key != gkey_q)) begin
                  // group break: flush, revisit this index afterwards
                  last_q  <= 1'b0;
                  state_q <= ST_EMIT;
               end else begin
                  if (cur_unreach) err_q <= 1'b1;
                  if (cur_hit && !cur_unreach) begin
                     open_q  <= 1'b1;
                     gkey_q  <= cur_key;
                     tlist_q <= (open_q ? tlist_q : '0) | (TLIST_W'(1) << cur_bit);
                  end
                  if (idx_q == LAST_IDX) begin
                     last_q  <= 1'b1;
                     state_q <= (open_q || (cur_hit && !cur_unreach)) ? ST_EMIT : ST_FIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_EMIT: if (cmd_ready_i) begin
               open_q  <= 1'b0;
               tlist_q <= '0;
               state_q <= last_q ? ST_FIN : ST_SCAN;
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sgi_rs_pack u_pack (
      .key_i   (gkey_q),
      .tlist_i (tlist_q),
      .intid_i (intid_q),
      .word_o  (cmd_word_o)
   );

   assign cmd_valid_o = (state_q == ST_EMIT);
   assign done_o      = (state_q == ST_FIN);
   assign err_o       = err_q;
endmodule

// File: rtl/sgi_rs_cmdgen_chk.sv
module sgi_rs_cmdgen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic [63:0] cmd_word,
   input logic        done,
   input logic        rs_en
);
   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word)); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid); // R8
   AST_TLIST_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_word[15:0] != 16'd0); // R3
   AST_RS_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !rs_en |-> cmd_word[47:44] == 4'd0); // R6
endmodule

bind sgi_rs_cmdgen sgi_rs_cmdgen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid_o),
   .cmd_ready (cmd_ready_i),
   .cmd_word  (cmd_word_o),
   .done      (done_o),
   .rs_en     (rs_en_q)
);

// File: tb/tb_sgi_rs_cmdgen.sv
module tb_sgi_rs_cmdgen;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [N-1:0]  cpu_mask_i = '0;
   logic [32*N-1:0] aff_tbl_i;
   logic [3:0]    intid_i = '0;
   logic          rs_sup_i = 1'b0;
   logic          cmd_valid_o;
   logic          cmd_ready_i = 1'b1;
   logic [63:0]   cmd_word_o;
   logic          done_o;
   logic          err_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   sgi_rs_cmdgen #(.NUM_CPU(N)) dut (.*);

   // rows {lvl3,lvl2,lvl1,lvl0}
   assign aff_tbl_i = {32'h05000020, 32'h00020000, 32'h00000007, 32'h00000101,
                       32'h0000001F, 32'h00000012, 32'h00000005, 32'h00000003};

   // {mask, intid, rs_sup}
   localparam logic [12:0] VEC [7] = '{
      {8'h03, 4'h1, 1'b1}, {8'hFF, 4'h7, 1'b1}, {8'hFF, 4'h2, 1'b0},
      {8'h0C, 4'hA, 1'b1}, {8'h21, 4'h4, 1'b1}, {8'h00, 4'h3, 1'b1},
      {8'h80, 4'hF, 1'b0}};

   logic [63:0] exp_w [16];
   int          exp_n;
   logic        exp_err;
   logic [63:0] got_w [16];
   int          got_n;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference from the requirements (R2 R3 R4 R5 R6 R9)
   task automatic model(input logic [N-1:0] m, input logic [3:0] id, input logic rs);
      logic [55:0] key;
      logic [15:0] tl;
      bit open;
      exp_n = 0; exp_err = 0; open = 0; key = '0; tl = '0;
      for (int i = 0; i < N; i++) begin
         logic [31:0] r;
         r = aff_tbl_i[32*i +: 32];
         if (m[i]) begin
            if (!rs && r[7:4] != 0) exp_err = 1;
            else begin
               if (open && key[27:0] != r[31:4]) begin
                  exp_w[exp_n] = {8'h0, key[27:20], key[3:0], 4'h0, key[19:12], 4'h0, id, key[11:4], tl};
                  exp_n++; tl = '0;
               end
               open = 1; key = {28'h0, r[31:4]}; tl |= 16'(1) << r[3:0];
            end
         end
      end
      if (open) begin
         exp_w[exp_n] = {8'h0, key[27:20], key[3:0], 4'h0, key[19:12], 4'h0, id, key[11:4], tl};
         exp_n++;
      end
   endtask

   task automatic run(input logic [N-1:0] m, input logic [3:0] id, input logic rs, input bit stall);
      int t;
      bit fin;
      @(negedge clk);
      cpu_mask_i = m; intid_i = id; rs_sup_i = rs; start_i = 1'b1;
      cmd_ready_i = !stall;
      @(negedge clk);
      start_i = 1'b0;
      got_n = 0; t = 0; fin = 0;
      if (stall) begin
         logic [63:0] w0;
         while (!cmd_valid_o && t < 100) begin @(negedge clk); t++; end
         w0 = cmd_word_o;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cmd_valid_o && cmd_word_o == w0, "R7 stall hold", cmd_word_o, w0);
         end
         cmd_ready_i = 1'b1;
      end
      while (!fin && t < 500) begin
         if (cmd_valid_o && cmd_ready_i && got_n < 16) begin
            got_w[got_n] = cmd_word_o; got_n++;
         end
         if (done_o) fin = 1;
         else begin @(negedge clk); t++; end
      end
      chk(fin, "R8 done seen (watchdog)", 64'(fin), 64'd1);
      @(negedge clk);
      chk(!done_o, "R8 done single cycle", 64'(done_o), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!cmd_valid_o && !done_o && !err_o, "R1 reset state", {cmd_valid_o, done_o, err_o}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < 7; v++) begin
         model(VEC[v][12:5], VEC[v][4:1], VEC[v][0]);
         run(VEC[v][12:5], VEC[v][4:1], VEC[v][0], 1'b0);
         chk(got_n == exp_n, "R4 R5 R8 command count", 64'(got_n), 64'(exp_n));
         for (int k = 0; k < exp_n && k < got_n; k++)
            chk(got_w[k] == exp_w[k], "R2 R3 R9 command word", got_w[k], exp_w[k]);
         chk(err_o == exp_err, "R6 error flag", 64'(err_o), 64'(exp_err));
      end

      // R7: backpressure on a two-command run
      model(8'h13, 4'h9, 1'b1);
      run(8'h13, 4'h9, 1'b1, 1'b1);
      chk(got_n == exp_n, "R7 count after stall", 64'(got_n), 64'(exp_n));
      for (int k = 0; k < exp_n && k < got_n; k++)
         chk(got_w[k] == exp_w[k], "R7 word after stall", got_w[k], exp_w[k]);

      // R6: error clears at next start
      run(8'h01, 4'h0, 1'b0, 1'b0);
      chk(!err_o, "R6 error cleared by start", 64'(err_o), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule